// File: doc/BRIEF.md
# Serial peripheral slave with start-of-frame preload

This block is the target side of a four-wire serial link in clock mode 0 (clock idles low, data captured on the rising clock edge, changed after the falling edge). An external master drives the serial clock, the master-out data line and an active-low select line. The block returns data on the master-in line. All three link inputs are brought into the system clock domain through two-flop synchronisers, and clock edges are found there. The link clock must therefore be well below the system clock.

Local logic writes the next outgoing character into a single data register. A flag reports when that register is empty. Each character completed on the link is handed to a downstream receive store as a one-cycle strobe with the character. When preload is off, the shift register starts a transaction with the value it already holds, which is zero after reset. The outgoing stream therefore runs one character behind the writes. When preload is on, a character written while the select line is high is moved into the shift register before the master starts. That character is then the first one sent.

Top module: `spi_tgt_preload`

## Requirements
- R1: While the synchronised select is high, clock and data activity on the link causes no shifting and no receive strobe, and the master-in output is driven low.
- R2: Transfers are full duplex and most-significant bit first. The master-out bit is captured on each rising clock edge. The shift register moves one place on the following falling edge, so the next outgoing bit appears on master-in.
- R3: With preload off, the first character sent after reset is 0x00. A character written before that transaction goes out as the second character, one character behind.
- R4: With preload on and a character pending while the select is high, that character is moved into the shift register before the transaction and is sent as the first character.
- R5: The master-in output shows the most-significant bit of the loaded character within 4 system clock cycles of the select line falling. This is the minimum setup the master must allow before its first rising clock edge.
- R6: The empty flag is high after reset. It is low in the cycle after a write. It goes high again in the cycle after the pending character is taken into the shift register, unless a new write arrives in the same cycle.
- R7: When a character completes, a pending character is loaded for the next one. If nothing is pending, the previously loaded character is sent again.
- R8: Each completed character raises the receive strobe for exactly one cycle. The receive data then holds the 8 bits taken from master-out, first bit in bit 7.
- R9: If the select line rises part-way through a character, that character is dropped without a strobe. The bit count restarts, and the shift register goes back to the character loaded for that slot, so the next transaction sends it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| sel_n_i | input | 1 | Active-low select from the master (asynchronous) |
| wr_en_i | input | 1 | Write strobe for the transmit data register |
| wr_data_i | input | DW | Character to transmit |
| preload_en_i | input | 1 | Enables loading the pending character while the select is high |
| miso_o | output | 1 | Serial data to the master |
| dre_o | output | 1 | Transmit data register empty |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_data_o | output | DW | Received character |

## Verification
The assertions check the following on every cycle:
- the shift register holds still while deselected, unless a preload is allowed;
- nothing is loaded while deselected with preload off;
- a pending character lands in the shift register on completion or preload;
- the empty flag follows writes and takes;
- a receive strobe never appears while deselected and never lasts two cycles.

The one-character lag without preload, the repeat of the last character when nothing is pending, and the resend after an aborted character depend on sequences of whole transactions. Only the bench scenarios can show them. The bench drives those transactions as a master and compares the captured master-in bits and the strobed characters against its expectations.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  // Source selected for the next shift-register value
  typedef enum logic [1:0] {
    LD_NONE,     // shift or hold
    LD_PRELOAD,  // pending character taken while deselected
    LD_NEXT,     // character boundary: pending or repeat
    LD_RESTORE   // select rose: back to the loaded character
  } load_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= RST_VAL[WIDTH-1:0];
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_txreg.sv
module spi_tgt_txreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          pend_o,
  output logic          dre_o
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_en_i) begin
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (take_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign pend_o = !empty_q;
  assign dre_o  = empty_q;

  AST_WR_CLEARS_DRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> !dre_o);                                          // R6
  AST_TAKE_SETS_DRE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !wr_en_i) |=> dre_o);                              // R6
  AST_IDLE_DRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !wr_en_i) |=> $stable(dre_o) && $stable(data_o)); // R6
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,     // synchronised select is low
  input  logic          abort_i,      // synchronised select rose
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic          preload_en_i,
  input  logic          pend_i,
  input  logic [DW-1:0] pend_data_i,
  output logic          take_o,
  output logic          complete_o,
  output logic [DW-1:0] rx_char_o,
  output logic          msb_o
);
  localparam int            CW   = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  function automatic logic [DW-1:0] shl_in(logic [DW-1:0] v, logic b);
    return {v[DW-2:0], b};
  endfunction

  logic [DW-1:0] sh_q, last_q, next_char;
  logic [CW-1:0] cnt_q;
  logic          samp_q;
  load_e         ld;

  always_comb begin
    ld = LD_NONE;
    if (abort_i)                             ld = LD_RESTORE;
    else if (active_i && rise_i && cnt_q == LAST) ld = LD_NEXT;
    else if (!active_i && preload_en_i && pend_i) ld = LD_PRELOAD;
  end

  assign next_char  = pend_i ? pend_data_i : last_q;
  assign take_o     = pend_i && (ld == LD_NEXT || ld == LD_PRELOAD);
  assign complete_o = (ld == LD_NEXT);
  assign rx_char_o  = shl_in(sh_q, mosi_i);
  assign msb_o      = sh_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
    end else begin
      unique case (ld)
        LD_RESTORE: begin
          sh_q  <= last_q;
          cnt_q <= '0;
        end
        LD_NEXT: begin
          sh_q   <= next_char;
          last_q <= next_char;
          cnt_q  <= '0;
        end
        LD_PRELOAD: begin
          sh_q   <= pend_data_i;
          last_q <= pend_data_i;
        end
        default: begin
          if (active_i && rise_i) begin
            samp_q <= mosi_i;
            cnt_q  <= cnt_q + 1'b1;
          end else if (active_i && fall_i && cnt_q != '0) begin
            sh_q <= shl_in(sh_q, samp_q);
          end
        end
      endcase
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !abort_i && !(preload_en_i && pend_i)) |=> $stable(sh_q)); // R1
  AST_NOPRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !abort_i && !preload_en_i) |=> $stable(sh_q));            // R3
  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !abort_i && preload_en_i && pend_i)
      |=> (sh_q == $past(pend_data_i)));                                   // R4
  AST_NEXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && pend_i) |=> (sh_q == $past(pend_data_i)));              // R7
endmodule

// File: rtl/spi_tgt_preload.sv
module spi_tgt_preload #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          sel_n_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          preload_en_i,
  output logic          miso_o,
  output logic          dre_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o
);
  logic [2:0]    pins_s;
  logic          sel_s, sck_s, mosi_s;
  logic          sel_prev_q, sck_prev_q;
  logic          sck_rise, sck_fall, sel_rise;
  logic          take, pend, complete, msb;
  logic [DW-1:0] pend_data, rx_char;
  logic          rx_valid_q;
  logic [DW-1:0] rx_data_q;

  spi_tgt_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(32'h4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sel_n_i, sck_i, mosi_i}),
    .sync_o  (pins_s)
  );
  assign {sel_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      sel_prev_q <= sel_s;
      sck_prev_q <= sck_s;
    end
  end

  assign sck_rise = sck_s && !sck_prev_q;
  assign sck_fall = !sck_s && sck_prev_q;
  assign sel_rise = sel_s && !sel_prev_q;

  spi_tgt_txreg #(.DW(DW)) u_txreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (pend_data),
    .pend_o    (pend),
    .dre_o     (dre_o)
  );

  spi_tgt_shift #(.DW(DW)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (!sel_s),
    .abort_i      (sel_rise),
    .rise_i       (sck_rise),
    .fall_i       (sck_fall),
    .mosi_i       (mosi_s),
    .preload_en_i (preload_en_i),
    .pend_i       (pend),
    .pend_data_i  (pend_data),
    .take_o       (take),
    .complete_o   (complete),
    .rx_char_o    (rx_char),
    .msb_o        (msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= complete;
      if (complete) rx_data_q <= rx_char;
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign miso_o     = !sel_s && msb;

  AST_NO_RX_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !rx_valid_o);                                       // R9
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);                                  // R8
endmodule

// File: tb/spi_tgt_preload_tb.sv
module spi_tgt_preload_tb;
  localparam int HALF = 6;  // system cycles per link clock half period

  logic       clk = 0, rst_n = 0;
  logic       sck = 0, mosi = 0, sel_n = 1, wr_en = 0, pre_en = 0;
  logic [7:0] wr_data = '0;
  logic       miso, dre, rx_valid;
  logic [7:0] rx_data;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  spi_tgt_preload #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .preload_en_i(pre_en),
    .miso_o(miso), .dre_o(dre), .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected characters as strobes appear
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected strobe", rx_data, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R8 received char", rx_data, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d);
    wr_data = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic start_txn(input logic [7:0] first, input string req);
    sel_n = 0;
    wait_cyc(4);
    check(miso == first[7], req, {7'b0, miso}, {7'b0, first[7]});  // R5 setup window
    wait_cyc(4);
  endtask

  task automatic end_txn();
    wait_cyc(HALF); sel_n = 1; wait_cyc(8);
  endtask

  // one character as master; pushes expected receive, checks master-in
  task automatic send_char(input logic [7:0] mo, input logic [7:0] exp, input string req);
    logic [7:0] got;
    exp_q.push_back(mo);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      wait_cyc(HALF);
      got[i] = miso;
      sck = 1; wait_cyc(HALF);
      sck = 0;
    end
    wait_cyc(HALF);
    check(got == exp, req, got, exp);
  endtask

  initial begin
    wait_cyc(5); rst_n = 1; wait_cyc(3);
    check(dre == 1'b1, "R6 reset empty", {7'b0, dre}, 8'h01);
    check(miso == 1'b0, "R1 reset miso", {7'b0, miso}, 8'h00);

    // R3: no preload, lag of one character
    write_char(8'hA5);
    check(dre == 1'b0, "R6 write clears empty", {7'b0, dre}, 8'h00);
    wait_cyc(10);
    check(dre == 1'b0, "R3 no load while idle", {7'b0, dre}, 8'h00);
    start_txn(8'h00, "R5 first bit");
    send_char(8'h3C, 8'h00, "R3 first char zero");
    check(dre == 1'b1, "R6 taken at boundary", {7'b0, dre}, 8'h01);
    send_char(8'h81, 8'hA5, "R3 lagged char");
    send_char(8'h7E, 8'hA5, "R7 repeat last");
    end_txn();

    // R1: activity while deselected
    for (int i = 0; i < 8; i++) begin
      mosi = i[0]; wait_cyc(HALF); sck = 1; wait_cyc(HALF); sck = 0;
      if (miso != 1'b0) check(1'b0, "R1 miso while idle", {7'b0, miso}, 8'h00);
    end
    check(miso == 1'b0, "R1 miso low deselected", {7'b0, miso}, 8'h00);
    start_txn(8'hA5, "R1 state kept");
    send_char(8'h42, 8'hA5, "R1 no shift when idle");
    end_txn();

    // R4: preload, then R7 load mid-transaction
    pre_en = 1;
    write_char(8'h5A);
    wait_cyc(3);
    check(dre == 1'b1, "R4 preload takes pending", {7'b0, dre}, 8'h01);
    start_txn(8'h5A, "R4 preload msb");
    fork
      send_char(8'hC3, 8'h5A, "R4 preloaded first char");
      begin wait_cyc(20); write_char(8'h96); end
    join
    send_char(8'h0F, 8'h96, "R7 pending loaded");
    end_txn();

    // R9: abort mid-character
    write_char(8'h11);
    wait_cyc(4);
    sel_n = 0; wait_cyc(8);
    for (int i = 0; i < 3; i++) begin
      mosi = 1; wait_cyc(HALF); sck = 1; wait_cyc(HALF); sck = 0;
    end
    wait_cyc(HALF); sel_n = 1; wait_cyc(10);
    check(miso == 1'b0, "R9 miso low after abort", {7'b0, miso}, 8'h00);
    check(exp_q.size() == 0, "R9 no pending expectation", 8'(exp_q.size()), 8'h00);
    start_txn(8'h11, "R9 restored msb");
    send_char(8'hE7, 8'h11, "R9 resent after abort");
    send_char(8'h24, 8'h11, "R2 full duplex repeat");
    end_txn();

    wait_cyc(10);
    check(exp_q.size() == 0, "R8 all chars strobed", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule